// File: doc/BRIEF.md
# Converter start pulse generator

This block drives the start-of-conversion line of an external analog-to-digital converter that feeds a fuzzy coprocessor. Whenever the coprocessor leaves its download phase (the offline level falls) or finishes a computation cycle (the busy level falls), the block waits a fixed ten-cycle settling interval and then emits one pulse. The pulse length is picked by a 3-bit code from an irregular table of lengths.

The pulse is only produced while the coprocessor is online. It is withheld entirely when the auto-boot strap is high. Its active level is set by a polarity bit. While a pulse is pending or running, further triggers are dropped, so exactly one conversion is started per accepted trigger.

Top module: `adcStartGen`

## Requirements
- R1: The pulse stays active for exactly 128, 256, 2040, 4080, 8160, 16320, 32000 or 65520 clock cycles for width codes 0, 1, 2, 3, 4, 5, 6 and 7 respectively.
- R2: A trigger is a falling edge of offlineMode or of busyLevel, seen as the level being 1 at one rising clock edge and 0 at the next.
- R3: The output turns active at the 10th rising edge after the edge at which the falling level is first sampled low.
- R4: A trigger is ignored when autoBoot is 1 at the edge at which it is sampled; no pulse follows.
- R5: While offlineMode is 1 no pulse is produced and triggers are ignored. When offlineMode is sampled 1, any pending delay or running pulse is dropped, and the output is inactive after that edge.
- R6: polarityHigh = 1 makes the active level 1 and the idle level 0. polarityHigh = 0 inverts both levels. The output follows polarityHigh without waiting for a clock edge.
- R7: A trigger that arrives during the start delay or during an active pulse is ignored. The current pulse keeps its timing and width.
- R8: A synchronous reset (rst = 1) drops any pending delay or pulse, forgets the last sampled trigger levels, and leaves the output at its idle level.
- R9: The width code is sampled at the edge where the pulse starts. Changes to it during the start delay or during the pulse do not alter the pulse already scheduled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| offlineMode | input | 1 | 1 while the coprocessor is in its download phase |
| busyLevel | input | 1 | 1 while a computation cycle is running |
| autoBoot | input | 1 | Auto-boot strap; 1 suppresses pulses |
| widthCode | input | 3 | Pulse width selector (see R1) |
| polarityHigh | input | 1 | 1 = active-high pulse, 0 = active-low pulse |
| startPulse | output | 1 | Start-of-conversion line to the converter |

## Verification
On every cycle, the embedded assertions check four things:
- sampling offlineMode high always returns the controller to idle;
- an idle controller with autoBoot high never arms;
- a running pulse cannot be cut short by a new trigger;
- the width counter is loaded from the table at the start edge, and a pulse only begins straight out of an expired start delay.

The exact width of each of the eight table entries, the ten-cycle start offset, the polarity inversion and the clearing effect of reset are shown only by the bench. Its behavioural model is compared against the output on every clock across each scenario.

// File: rtl/adcStartPkg.sv
package adcStartPkg;

  localparam int CNT_W  = 16;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_PULSE = 2'd2
  } genStateT;

  typedef struct packed {
    logic armDelay;
    logic tickDelay;
    logic startWidth;
    logic tickWidth;
    logic clearAll;
  } genStrobeT;

  // Irregular pulse length table, indexed by the width code
  function automatic logic [CNT_W-1:0] widthLookup(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] len;
    case (code)
      3'd0:    len = CNT_W'(128);
      3'd1:    len = CNT_W'(256);
      3'd2:    len = CNT_W'(2040);
      3'd3:    len = CNT_W'(4080);
      3'd4:    len = CNT_W'(8160);
      3'd5:    len = CNT_W'(16320);
      3'd6:    len = CNT_W'(32000);
      default: len = CNT_W'(65520);
    endcase
    return len;
  endfunction

endpackage

// File: rtl/adcStartCtrl.sv
module adcStartCtrl
  import adcStartPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      offlineMode,
  input  logic      busyLevel,
  input  logic      autoBoot,
  input  logic      delayZero,
  input  logic      widthZero,
  output genStrobeT strobes,
  output logic      pulseOn
);

  genStateT state, stateNext;
  logic offPrev, busyPrev;
  logic fallSeen, accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      offPrev  <= 1'b0;
      busyPrev <= 1'b0;
      state    <= ST_IDLE;
    end else begin
      offPrev  <= offlineMode;
      busyPrev <= busyLevel;
      state    <= stateNext;
    end
  end

  assign fallSeen = (offPrev && !offlineMode) || (busyPrev && !busyLevel);
  assign accept   = fallSeen && !offlineMode && !autoBoot;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    strobes.clearAll = offlineMode;
    if (offlineMode) begin
      stateNext = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            stateNext        = ST_DELAY;
            strobes.armDelay = 1'b1;
          end
        end
        ST_DELAY: begin
          if (delayZero) begin
            stateNext          = ST_PULSE;
            strobes.startWidth = 1'b1;
          end else begin
            strobes.tickDelay = 1'b1;
          end
        end
        ST_PULSE: begin
          if (widthZero) stateNext = ST_IDLE;
          else           strobes.tickWidth = 1'b1;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  assign pulseOn = (state == ST_PULSE);

  // R5: sampling the offline level always ends in idle
  a_r5_offline_idles: assert property (@(posedge clk) disable iff (rst)
    offlineMode |=> (state == ST_IDLE));

  // R4: an idle controller never arms while auto-boot is strapped
  a_r4_autoboot_blocks: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && autoBoot) |=> (state == ST_IDLE));

  // R7: a running pulse is not cut short by a trigger
  a_r7_no_retrigger: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PULSE && !offlineMode && !widthZero) |=> (state == ST_PULSE));

  // R3: a pulse only begins out of an expired start delay
  a_r3_start_after_delay: assert property (@(posedge clk) disable iff (rst)
    $rose(pulseOn) |-> ($past(state) == ST_DELAY && $past(delayZero)));

endmodule

// File: rtl/adcStartData.sv
module adcStartData
  import adcStartPkg::*;
#(
  parameter int DELAY_CYC = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  genStrobeT         strobes,
  input  logic [CODE_W-1:0] widthCode,
  output logic              delayZero,
  output logic              widthZero
);

  localparam int DLY_W = $clog2(DELAY_CYC + 1);

  logic [DLY_W-1:0] delayCnt;
  logic [CNT_W-1:0] widthCnt;

  always_ff @(posedge clk) begin
    if (rst || strobes.clearAll) begin
      delayCnt <= '0;
      widthCnt <= '0;
    end else begin
      if (strobes.armDelay)       delayCnt <= DLY_W'(DELAY_CYC - 1);
      else if (strobes.tickDelay) delayCnt <= delayCnt - DLY_W'(1);

      if (strobes.startWidth)     widthCnt <= widthLookup(widthCode) - CNT_W'(1);
      else if (strobes.tickWidth) widthCnt <= widthCnt - CNT_W'(1);
    end
  end

  assign delayZero = (delayCnt == '0);
  assign widthZero = (widthCnt == '0);

  // R9 / R1: the width counter takes the table length of the code seen at start
  a_r9_width_load: assert property (@(posedge clk) disable iff (rst)
    (strobes.startWidth && !strobes.clearAll) |=>
      (widthCnt == widthLookup($past(widthCode)) - CNT_W'(1)));

  // R3: the start delay counter never exceeds the delay span
  a_r3_delay_bound: assert property (@(posedge clk) disable iff (rst)
    delayCnt <= DLY_W'(DELAY_CYC - 1));

endmodule

// File: rtl/adcStartGen.sv
module adcStartGen
  import adcStartPkg::*;
#(
  parameter int DELAY_CYC = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              offlineMode,
  input  logic              busyLevel,
  input  logic              autoBoot,
  input  logic [CODE_W-1:0] widthCode,
  input  logic              polarityHigh,
  output logic              startPulse
);

  genStrobeT strobes;
  logic delayZero, widthZero, pulseOn;

  adcStartCtrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .offlineMode (offlineMode),
    .busyLevel   (busyLevel),
    .autoBoot    (autoBoot),
    .delayZero   (delayZero),
    .widthZero   (widthZero),
    .strobes     (strobes),
    .pulseOn     (pulseOn)
  );

  adcStartData #(.DELAY_CYC(DELAY_CYC)) data_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .widthCode (widthCode),
    .delayZero (delayZero),
    .widthZero (widthZero)
  );

  // R6: polarity selects the active level
  assign startPulse = polarityHigh ? pulseOn : !pulseOn;

endmodule

// File: tb/adcStartGen_tb_top.sv
module adcStartGen_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic offlineMode = 1'b1;
  logic busyLevel = 1'b0;
  logic autoBoot = 1'b0;
  logic [2:0] widthCode = 3'd0;
  logic polarityHigh = 1'b1;
  logic startPulse;

  int total = 0;
  int bad = 0;
  bit started = 0;
  bit finished = 0;
  string reqTag = "R8";
  longint cycle = 0;

  always #10 clk = ~clk;

  adcStartGen dut_i (
    .clk          (clk),
    .rst          (rst),
    .offlineMode  (offlineMode),
    .busyLevel    (busyLevel),
    .autoBoot     (autoBoot),
    .widthCode    (widthCode),
    .polarityHigh (polarityHigh),
    .startPulse   (startPulse)
  );

  function automatic int tabLen(input int c);
    case (c)
      0: return 128;
      1: return 256;
      2: return 2040;
      3: return 4080;
      4: return 8160;
      5: return 16320;
      6: return 32000;
      default: return 65520;
    endcase
  endfunction

  // Behavioural reference: remaining delay and remaining pulse cycles
  int mDelay = -1;
  int mPulse = 0;
  bit mOffPrev = 0;
  bit mBusyPrev = 0;

  always @(posedge clk) begin
    bit fall;
    cycle++;
    started = 1;
    if (rst) begin
      mDelay = -1; mPulse = 0; mOffPrev = 0; mBusyPrev = 0;
    end else begin
      fall = (mOffPrev && !offlineMode) || (mBusyPrev && !busyLevel);
      if (offlineMode) begin
        mDelay = -1; mPulse = 0;
      end else if (mPulse > 0) begin
        mPulse--;
      end else if (mDelay >= 0) begin
        if (mDelay == 0) begin
          mPulse = tabLen(int'(widthCode));
          mDelay = -1;
        end else begin
          mDelay--;
        end
      end else if (fall && !autoBoot) begin
        mDelay = 9;
      end
      mOffPrev = offlineMode;
      mBusyPrev = busyLevel;
    end
  end

  always @(negedge clk) begin
    logic expv;
    if (started && !finished) begin
      expv = (mPulse > 0) ? polarityHigh : !polarityHigh;
      total++;
      if (startPulse !== expv) begin
        bad++;
        $display("FAIL %s cycle %0d: startPulse=%0b expected=%0b", reqTag, cycle, startPulse, expv);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #3;
    end
  endtask

  task automatic busyFall();
    busyLevel = 1'b1;
    tick(1);
    busyLevel = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R8: reset state is idle level
    reqTag = "R8";
    tick(3);
    rst = 1'b0;
    tick(2);

    // R2, R3: offline fall triggers a 128-cycle pulse 10 edges later
    reqTag = "R3";
    widthCode = 3'd0;
    offlineMode = 1'b0;
    tick(10 + 128 + 5);

    // R1: busy fall with every table entry
    reqTag = "R1";
    for (int c = 1; c < 8; c++) begin
      widthCode = 3'(c);
      busyFall();
      tick(10 + tabLen(c) + 3);
    end

    // R4: auto-boot strap suppresses the trigger
    reqTag = "R4";
    widthCode = 3'd0;
    autoBoot = 1'b1;
    busyFall();
    tick(40);
    autoBoot = 1'b0;
    tick(2);

    // R5: busy fall while offline is ignored, then offline abort mid pulse
    reqTag = "R5";
    offlineMode = 1'b1;
    tick(2);
    busyFall();
    tick(40);
    offlineMode = 1'b0;
    tick(50);
    offlineMode = 1'b1;
    tick(10);
    offlineMode = 1'b0;

    // R7: triggers during delay and during pulse are ignored
    reqTag = "R7";
    tick(3);
    busyFall();
    tick(50);
    busyFall();
    tick(120);

    // R9: width code changes during delay and pulse are ignored
    reqTag = "R9";
    busyFall();
    tick(3);
    widthCode = 3'd1;
    tick(20);
    widthCode = 3'd0;
    tick(300);

    // R6: active-low polarity
    reqTag = "R6";
    polarityHigh = 1'b0;
    tick(3);
    busyFall();
    tick(150);
    polarityHigh = 1'b1;
    tick(3);

    // R8: reset in the middle of a start delay
    reqTag = "R8";
    busyFall();
    tick(4);
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(40);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule